// File: doc/BRIEF.md
# Performance monitor counter unit

This block counts traffic events for an on-chip interconnect. It holds a bank of 32-bit event counters and one 64-bit free-running cycle counter. Each event counter has a selector register that holds a node type and a node ID. Every cycle the counter compares its selector against a small bus of event lanes. Each lane carries a valid strobe, a 4-bit node type and a 9-bit node ID. A counter advances by one when any valid lane matches its selector.

Software drives the unit through a simple 32-bit read/write port. Per-counter state is kept in three bitmasks: counter enable, interrupt enable and overflow status. Each mask has one address where a written 1 sets bits and another where a written 1 clears them. In all three masks the event counters sit at the low bits and the cycle counter sits at bit 31. A control word holds a global run bit and two self-clearing reset strobes. A wrapping counter marks overflow, and a level interrupt is raised while any overflow bit is also interrupt-enabled.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset all counters, selectors and masks are zero, the run bit is clear, `irq` is low and `rd_valid` is low.
- R2: Event counter n is read and written at byte address 0x008+8n, and the word at 0x00C+8n reads zero. Selector n is at 0x400+4n, holds bits 12:0 (type in 12:9, ID in 8:0) and reads zero above them. The cycle counter is reached as a low word at 0x0F8 and a high word at 0x0FC.
- R3: Counter enable is set at 0xC00 and cleared at 0xC20, and interrupt enable is set at 0xC40 and cleared at 0xC60. A written 1 acts on its bit and a written 0 leaves the bit alone. Either address of a pair reads the current mask. Bits 8 to 30 always read zero.
- R4: With the run bit (control bit 0) and its enable bit set, event counter n adds exactly one in each cycle in which at least one lane is valid with a type and ID equal to selector n. This holds even when several lanes match at once.
- R5: With the run bit and enable bit 31 set, the cycle counter adds one every clock and carries from the low word into the high word.
- R6: A counter holds its value when the run bit or its own enable bit is clear.
- R7: Writing the control word at 0xE04 with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter, on that write. Neither bit is stored, so the control word reads back only bit 0. Enables and overflow bits are unchanged.
- R8: An increment from all ones to zero sets the counter's overflow bit. Event counters wrap at 32 bits and the cycle counter at 64 bits. Overflow bits are set by writing 1 at 0xCC0, cleared by writing 1 at 0xC80, and read at either address. An overflow bit stays set until cleared. A wrap wins over a clear in the same cycle.
- R9: `irq` is high exactly when some bit is set in both overflow status and interrupt enable. It reflects a write or wrap from the same clock edge that updates the state.
- R10: A write to a counter word in the same cycle as a qualifying increment loads the written value, and the increment is dropped.
- R11: A read request captured on a clock edge presents its data on `rdata` with `rd_valid` high after that edge. `rd_valid` is low after an edge with no request.
- R12: The configuration word at 0xE00 reads non-zero: the event counter width in bits 15:8 and the counter count in bits 7:0, which is 0x2008 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for the cycle after a read request |
| ev_valid | input | LANES (2) | Per-lane event strobe |
| ev_type | input | 4*LANES | Per-lane node type, lane 0 in the low bits |
| ev_id | input | 9*LANES | Per-lane node ID, lane 0 in the low bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: eight event counters, two event lanes and a 64-bit cycle counter. With two lanes the bench can show a double match counting once, and a match on the second lane alone. Preloading counters to just below all ones puts both the 32-bit and the 64-bit wrap within a few cycles. The same preloads let the bench test a wrap against an overflow clear, and a load against an increment, each in one cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int CYC_BIT = 31;

  localparam logic [AW-1:0] A_EVT_BASE  = 12'h008;
  localparam logic [AW-1:0] A_CYC_LO    = 12'h0F8;
  localparam logic [AW-1:0] A_CYC_HI    = 12'h0FC;
  localparam logic [AW-1:0] A_SEL_BASE  = 12'h400;
  localparam logic [AW-1:0] A_CNTEN_SET = 12'hC00;
  localparam logic [AW-1:0] A_CNTEN_CLR = 12'hC20;
  localparam logic [AW-1:0] A_INTEN_SET = 12'hC40;
  localparam logic [AW-1:0] A_INTEN_CLR = 12'hC60;
  localparam logic [AW-1:0] A_OVS_CLR   = 12'hC80;
  localparam logic [AW-1:0] A_OVS_SET   = 12'hCC0;
  localparam logic [AW-1:0] A_CFG       = 12'hE00;
  localparam logic [AW-1:0] A_CTRL      = 12'hE04;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_RST_EVT = 1;
  localparam int CTRL_RST_CYC = 2;

  function automatic logic [AW-1:0] evt_addr(input int idx);
    return A_EVT_BASE + AW'(8 * idx);
  endfunction

  function automatic logic [AW-1:0] sel_addr(input int idx);
    return A_SEL_BASE + AW'(4 * idx);
  endfunction
endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match #(
  parameter int LANES  = 2,
  parameter int TYPE_W = 4,
  parameter int ID_W   = 9
) (
  input  logic [TYPE_W+ID_W-1:0]  sel,
  input  logic [LANES-1:0]        ev_valid,
  input  logic [LANES*TYPE_W-1:0] ev_type,
  input  logic [LANES*ID_W-1:0]   ev_id,
  output logic                    hit
);
  logic [LANES-1:0] lane_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = ev_valid[l]
      && (ev_type[l*TYPE_W +: TYPE_W] == sel[ID_W +: TYPE_W])
      && (ev_id[l*ID_W +: ID_W] == sel[ID_W-1:0]);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  assign wrap = inc && !ld && !clr && (&cnt);
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64,
  parameter int LANES   = 2,
  parameter int TYPE_W  = 4,
  parameter int ID_W    = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    rd_valid,
  input  logic [LANES-1:0]        ev_valid,
  input  logic [LANES*TYPE_W-1:0] ev_type,
  input  logic [LANES*ID_W-1:0]   ev_id,
  output logic                    irq
);
  localparam int SEL_W = TYPE_W + ID_W;
  localparam logic [DW-1:0] IMPL = (DW'(1) << CYC_BIT) | ((DW'(1) << NUM_EVT) - DW'(1));
  localparam logic [DW-1:0] CFG_VAL = {16'h0, 8'(EVT_W), 8'(NUM_EVT)};

  logic              glb_en_q;
  logic [DW-1:0]     cnten_q, inten_q, ovs_q;
  logic [DW-1:0]     cnten_d, inten_d, ovs_d, wrap_vec;
  logic [SEL_W-1:0]  sel_q [NUM_EVT];
  logic [EVT_W-1:0]  evt_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap, hit;
  logic [CYC_W-1:0]  cyc_cnt, cyc_ld_val;
  logic              cyc_wrap, cyc_ld_lo, cyc_ld_hi;
  logic              ctrl_wr, evt_clr, cyc_clr;
  logic [DW-1:0]     rd_nxt, rdata_q;
  logic              rd_valid_q, irq_q;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign evt_clr = ctrl_wr && wdata[CTRL_RST_EVT];
  assign cyc_clr = ctrl_wr && wdata[CTRL_RST_CYC];

  // Event counters with their selectors and matchers
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic ld;
    assign ld = wr_en && (addr == evt_addr(i));

    pmu_evt_match #(.LANES(LANES), .TYPE_W(TYPE_W), .ID_W(ID_W)) u_match (
      .sel(sel_q[i]), .ev_valid(ev_valid), .ev_type(ev_type), .ev_id(ev_id), .hit(hit[i])
    );

    pmu_counter #(.W(EVT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(evt_clr), .ld(ld), .ld_val(wdata[EVT_W-1:0]),
      .inc(glb_en_q && cnten_q[i] && hit[i]), .cnt(evt_cnt[i]), .wrap(evt_wrap[i])
    );

    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= '0;
      else if (wr_en && (addr == sel_addr(i))) sel_q[i] <= wdata[SEL_W-1:0];
    end
  end

  // Cycle counter, loaded one 32-bit half at a time
  assign cyc_ld_lo  = wr_en && (addr == A_CYC_LO);
  assign cyc_ld_hi  = wr_en && (addr == A_CYC_HI);
  assign cyc_ld_val = cyc_ld_hi ? {wdata[CYC_W-33:0], cyc_cnt[31:0]}
                                : {cyc_cnt[CYC_W-1:32], wdata};

  pmu_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst(rst), .clr(cyc_clr), .ld(cyc_ld_lo || cyc_ld_hi), .ld_val(cyc_ld_val),
    .inc(glb_en_q && cnten_q[CYC_BIT]), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  // Set/clear bitmasks
  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;

    cnten_d = cnten_q;
    inten_d = inten_q;
    ovs_d   = ovs_q;
    if (wr_en && addr == A_CNTEN_SET) cnten_d = cnten_q | (wdata & IMPL);
    if (wr_en && addr == A_CNTEN_CLR) cnten_d = cnten_q & ~wdata;
    if (wr_en && addr == A_INTEN_SET) inten_d = inten_q | (wdata & IMPL);
    if (wr_en && addr == A_INTEN_CLR) inten_d = inten_q & ~wdata;
    if (wr_en && addr == A_OVS_SET)   ovs_d   = ovs_q | (wdata & IMPL);
    if (wr_en && addr == A_OVS_CLR)   ovs_d   = ovs_q & ~wdata;
    ovs_d = ovs_d | wrap_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnten_q  <= '0;
      inten_q  <= '0;
      ovs_q    <= '0;
      glb_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnten_q <= cnten_d;
      inten_q <= inten_d;
      ovs_q   <= ovs_d;
      irq_q   <= |(ovs_d & inten_d);
      if (ctrl_wr) glb_en_q <= wdata[CTRL_RUN];
    end
  end

  // Read path
  always_comb begin
    rd_nxt = '0;
    case (addr)
      A_CYC_LO:                 rd_nxt = cyc_cnt[31:0];
      A_CYC_HI:                 rd_nxt = DW'(cyc_cnt[CYC_W-1:32]);
      A_CNTEN_SET, A_CNTEN_CLR: rd_nxt = cnten_q;
      A_INTEN_SET, A_INTEN_CLR: rd_nxt = inten_q;
      A_OVS_SET, A_OVS_CLR:     rd_nxt = ovs_q;
      A_CFG:                    rd_nxt = CFG_VAL;
      A_CTRL:                   rd_nxt = DW'(glb_en_q);
      default:                  rd_nxt = '0;
    endcase
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr == evt_addr(i)) rd_nxt = DW'(evt_cnt[i]);
      if (addr == sel_addr(i)) rd_nxt = DW'(sel_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_nxt;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;
  assign irq      = irq_q;
endmodule

// File: rtl/pmu_counter_unit_chk.sv
module pmu_counter_unit_chk
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int CYC_W   = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             rd_valid,
  input logic             irq,
  input logic             glb_en,
  input logic [DW-1:0]    cnten,
  input logic [DW-1:0]    inten,
  input logic [DW-1:0]    ovs,
  input logic [CYC_W-1:0] cyc
);
  localparam logic [DW-1:0] UNIMPL = ~((DW'(1) << CYC_BIT) | ((DW'(1) << NUM_EVT) - DW'(1)));

  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (|(ovs & inten)));

  a_r8_ovs_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_OVS_CLR) |=> ((ovs & $past(ovs)) == $past(ovs)));

  a_r6_cyc_hold: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !wr_en) |=> $stable(cyc));

  a_r5_cyc_step: assert property (@(posedge clk) disable iff (rst)
    (glb_en && cnten[CYC_BIT] && !wr_en) |=> (cyc == CYC_W'($past(cyc) + CYC_W'(1))));

  a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    ((cnten | inten | ovs) & UNIMPL) == '0);

  a_r11_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(.NUM_EVT(NUM_EVT), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rd_valid(rd_valid),
  .irq(irq), .glb_en(glb_en_q), .cnten(cnten_q), .inten(inten_q), .ovs(ovs_q), .cyc(cyc_cnt)
);

// File: tb/pmu_counter_unit_tb.sv
module pmu_counter_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid, irq;
  logic [1:0]  ev_valid = '0;
  logic [7:0]  ev_type = '0;
  logic [17:0] ev_id = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmu_counter_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_id(ev_id), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [1:0] v, input logic [7:0] t, input logic [17:0] i);
    ev_valid = v; ev_type = t; ev_id = i;
    @(negedge clk);
    ev_valid = '0;
  endtask

  // lane 0 and lane 1 matching node type 3, ID 5 (selector 0x605)
  localparam logic [7:0]  T_MATCH = {4'd3, 4'd3};
  localparam logic [17:0] I_MATCH = {9'd5, 9'd5};

  task automatic wr_with_event(input logic [11:0] a, input logic [31:0] d);
    ev_valid = 2'b01; ev_type = T_MATCH; ev_id = I_MATCH;
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_valid = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    rd(12'hC00, 32'h0, "R1 cnten");
    rd(12'hC80, 32'h0, "R1 ovs");
    rd(12'h008, 32'h0, "R1 evt0");
    rd(12'h0F8, 32'h0, "R1 cyc lo");
    rd(12'hE04, 32'h0, "R1 ctrl");
    @(negedge clk);
    chk("R11 rd_valid idle", {31'b0, rd_valid}, 32'd0);
    rd(12'hE00, 32'h0000_2008, "R12 cfg");
  endtask

  task automatic t_map;
    wr(12'h040, 32'hA5A5_0001);
    rd(12'h040, 32'hA5A5_0001, "R2 evt7");
    rd(12'h044, 32'h0, "R2 upper word");
    wr(12'h41C, 32'hFFFF_FFFF);
    rd(12'h41C, 32'h0000_1FFF, "R2 sel7");
    wr(12'h0F8, 32'h0000_1234);
    wr(12'h0FC, 32'h0000_ABCD);
    rd(12'h0F8, 32'h0000_1234, "R2 cyc lo");
    rd(12'h0FC, 32'h0000_ABCD, "R2 cyc hi");
  endtask

  task automatic t_masks;
    wr(12'hC00, 32'hFFFF_FFFF);
    rd(12'hC00, 32'h8000_00FF, "R3 cnten set");
    wr(12'hC20, 32'h0000_000F);
    rd(12'hC20, 32'h8000_00F0, "R3 cnten clr");
    wr(12'hC00, 32'h0);
    rd(12'hC00, 32'h8000_00F0, "R3 zero ignored");
    wr(12'hC20, 32'hFFFF_FFFF);
    rd(12'hC00, 32'h0, "R3 cnten all clr");
    wr(12'hC40, 32'h8000_0003);
    rd(12'hC60, 32'h8000_0003, "R3 inten");
    wr(12'hC60, 32'hFFFF_FFFF);
    rd(12'hC40, 32'h0, "R3 inten clr");
  endtask

  task automatic t_events;
    wr(12'h400, 32'h605);
    wr(12'h404, 32'h605);
    wr(12'h008, 32'h0);
    wr(12'h010, 32'h0);
    wr(12'hC00, 32'h1);
    wr(12'hE04, 32'h1);
    pulse(2'b01, T_MATCH, I_MATCH);
    pulse(2'b01, T_MATCH, I_MATCH);
    pulse(2'b10, T_MATCH, I_MATCH);
    pulse(2'b11, T_MATCH, I_MATCH);
    pulse(2'b10, T_MATCH, {9'd6, 9'd5});
    pulse(2'b01, {4'd3, 4'd2}, I_MATCH);
    wr(12'hE04, 32'h0);
    pulse(2'b01, T_MATCH, I_MATCH);
    rd(12'h008, 32'd4, "R4 match count");
    rd(12'h010, 32'd0, "R6 counter disabled");
  endtask

  task automatic t_cycle;
    wr(12'hC20, 32'hFFFF_FFFF);
    wr(12'hC00, 32'h8000_0000);
    wr(12'h0F8, 32'hFFFF_FFFE);
    wr(12'h0FC, 32'h0);
    wr(12'hE04, 32'h1);
    repeat (2) @(negedge clk);
    wr(12'hE04, 32'h0);
    rd(12'h0F8, 32'h1, "R5 cyc lo");
    rd(12'h0FC, 32'h1, "R5 cyc carry");
    repeat (3) @(negedge clk);
    rd(12'h0F8, 32'h1, "R6 cyc held");
  endtask

  task automatic t_reset_bits;
    wr(12'h008, 32'd5);
    wr(12'h0F8, 32'd7);
    wr(12'hE04, 32'h2);
    rd(12'h008, 32'h0, "R7 evt zeroed");
    rd(12'h0F8, 32'd7, "R7 cyc kept");
    rd(12'hE04, 32'h0, "R7 self clear");
    wr(12'hE04, 32'h4);
    rd(12'h0F8, 32'h0, "R7 cyc zeroed");
    rd(12'hC00, 32'h8000_0000, "R7 enables kept");
  endtask

  task automatic t_wrap;
    wr(12'hC00, 32'h1);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'hE04, 32'h1);
    pulse(2'b01, T_MATCH, I_MATCH);
    wr(12'hE04, 32'h0);
    rd(12'h008, 32'h0, "R8 evt wrapped");
    rd(12'hC80, 32'h1, "R8 evt ovs");
    chk("R9 irq masked", {31'b0, irq}, 32'd0);
    wr(12'hC40, 32'h1);
    chk("R9 irq on enable", {31'b0, irq}, 32'd1);
    wr(12'hC80, 32'h1);
    chk("R9 irq on clear", {31'b0, irq}, 32'd0);
    rd(12'hCC0, 32'h0, "R8 ovs cleared");
    wr(12'h0F8, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'hE04, 32'h1);
    wr(12'hE04, 32'h0);
    rd(12'hC80, 32'h8000_0000, "R8 cyc ovs");
    rd(12'h0FC, 32'h0, "R8 cyc wrapped");
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'hE04, 32'h1);
    wr_with_event(12'hC80, 32'hFFFF_FFFF);
    wr(12'hE04, 32'h0);
    rd(12'hC80, 32'h1, "R8 wrap beats clear");
    wr(12'hC80, 32'hFFFF_FFFF);
    wr(12'hC40, 32'h4);
    wr(12'hCC0, 32'h4);
    chk("R9 irq on ovs set", {31'b0, irq}, 32'd1);
    wr(12'hC60, 32'h4);
    chk("R9 irq off on inten clr", {31'b0, irq}, 32'd0);
    rd(12'hC80, 32'h4, "R8 ovs sticky");
    wr(12'hC80, 32'hFFFF_FFFF);
  endtask

  task automatic t_write_prio;
    wr(12'hE04, 32'h1);
    wr_with_event(12'h008, 32'h100);
    wr(12'hE04, 32'h0);
    rd(12'h008, 32'h100, "R10 write beats inc");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_masks();
    t_events();
    t_cycle();
    t_reset_bits();
    t_wrap();
    t_write_prio();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule